// File: doc/BRIEF.md
# Operand-Wait Issue Queue With Tag Wakeup and Age Select

This block sits between the rename/dispatch stage and the function units of an out-of-order core. Each dispatched instruction is parked in a slot of the unit class it needs. The slot records the opcode, the destination tag, two source tags with ready flags, and an age number taken from the reorder-buffer index. A completion broadcast carries the tag of a finished result. Every waiting source holding that tag marks itself ready. Once all of a slot's used sources are ready, the slot competes for the single issue port. The oldest contender wins. The winning slot is held until the execute-done input names it, and only then is it released.

Each slot runs a three-state machine. SLOT_FREE goes to SLOT_WAIT on the *alloc* transition, when dispatch writes the slot. SLOT_WAIT goes to SLOT_ISSUED on the *grant* transition, when the selector picks the slot. SLOT_ISSUED goes back to SLOT_FREE on the *release* transition, when execute-done names the slot. In every other case a slot stays in its state. Dispatch into a class with no free slot is refused, and the refusal is shown on a stall output in the same cycle.

Top module: `resv_station`

## Requirements
- R1: After reset every slot is free and `issue_valid` is 0.
- R2: Class codes are 0 add, 1 multiply, 2 load and 3 store, with 1, 2, 2 and 2 slots. Slots are numbered add 0, multiply 1–2, load 3–4 and store 5–6. A dispatch takes the lowest-numbered free slot of its class, and `issue_class` reports the class of the issued slot.
- R3: When `disp_valid` is high and the requested class has no free slot, `disp_stall` is high in that cycle and nothing is written. `disp_stall` is never high without `disp_valid`.
- R4: A slot becomes eligible only when every source it uses is ready. A source flagged as unused counts as ready.
- R5: A broadcast with `cdb_valid` sets the ready flag of every waiting source whose tag equals `cdb_tag`. The slot may issue from the next cycle.
- R6: A source whose tag is broadcast in the same cycle it is dispatched is stored as ready.
- R7: At most one slot issues per cycle. Whenever any slot is eligible, one of them issues. The winner is the oldest, where age a is older than b when bit SEQ_W-1 of (a − b) mod 2^SEQ_W is 1.
- R8: An issued slot is not selected again. It stays occupied until released.
- R9: `done_valid` with `done_slot` naming an issued slot frees that slot, and the slot can accept a dispatch from the next cycle. A done aimed at a free or waiting slot is ignored.
- R10: A store carries no destination, so a store issue always shows `issue_dst` = 0. Its sources are the address base (A) and the store data (B).
- R11: While `issue_valid` is high, `issue_slot`, `issue_op`, `issue_dst` and `issue_seq` give the winning slot's stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_class | input | 2 | Unit class of the dispatched instruction |
| disp_op | input | OP_W | Opcode |
| disp_dst | input | TAG_W | Destination tag (ignored for stores) |
| disp_src_a | input | TAG_W | Source A tag |
| disp_use_a | input | 1 | Source A is used |
| disp_rdy_a | input | 1 | Source A already available |
| disp_src_b | input | TAG_W | Source B tag |
| disp_use_b | input | 1 | Source B is used |
| disp_rdy_b | input | 1 | Source B already available |
| disp_seq | input | SEQ_W | Age number (reorder-buffer index) |
| disp_stall | output | 1 | Dispatch refused, class full |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Broadcast result tag |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_slot | output | SLOT_W | Slot number of the issued instruction |
| issue_class | output | 2 | Unit class of the issued instruction |
| issue_op | output | OP_W | Opcode issued |
| issue_dst | output | TAG_W | Destination tag issued (0 for stores) |
| issue_seq | output | SEQ_W | Age number issued |
| done_valid | input | 1 | Execute-done strobe |
| done_slot | input | SLOT_W | Slot whose execution finished |

## Verification
The hardest situation to reach is the age selector comparing numbers that straddle the wrap of the age counter while several classes are ready at once. Sequential dispatch hides the wrap because the oldest entry usually issues alone. The directed part therefore starts the age counter two steps below the wrap and parks two loads and a store behind one shared tag. It then fires that tag so all three become eligible together. The random part runs thousands of cycles with a small tag pool, so broadcasts often match. This keeps ages wrapping repeatedly and keeps the queue full enough to hit stalls, same-cycle captures and stray done pulses aimed at waiting slots.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'd0,
        CLS_MUL   = 2'd1,
        CLS_LOAD  = 2'd2,
        CLS_STORE = 2'd3
    } unit_cls_e;

    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_WAIT   = 2'd1,
        SLOT_ISSUED = 2'd2
    } slot_state_e;

endpackage

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int OP_W  = 4,
    parameter int SEQ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [TAG_W-1:0] dst_i,
    input  logic [TAG_W-1:0] tag_a_i,
    input  logic             use_a_i,
    input  logic             rdy_a_i,
    input  logic [TAG_W-1:0] tag_b_i,
    input  logic             use_b_i,
    input  logic             rdy_b_i,
    input  logic [SEQ_W-1:0] seq_i,
    input  logic             cdb_valid_i,
    input  logic [TAG_W-1:0] cdb_tag_i,
    input  logic             grant_i,
    input  logic             done_i,
    output logic             free_o,
    output logic             elig_o,
    output logic [OP_W-1:0]  op_o,
    output logic [TAG_W-1:0] dst_o,
    output logic [SEQ_W-1:0] seq_o
);

    slot_state_e      state_q, state_d;
    logic [TAG_W-1:0] tag_a_q, tag_b_q;
    logic             rdy_a_q, rdy_b_q;
    logic             hit_a, hit_b;
    logic             cap_a, cap_b;

    assign hit_a = cdb_valid_i && (cdb_tag_i == tag_a_q);
    assign hit_b = cdb_valid_i && (cdb_tag_i == tag_b_q);
    assign cap_a = rdy_a_i || !use_a_i || (cdb_valid_i && (cdb_tag_i == tag_a_i));
    assign cap_b = rdy_b_i || !use_b_i || (cdb_valid_i && (cdb_tag_i == tag_b_i));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:   if (alloc_i) state_d = SLOT_WAIT;
            SLOT_WAIT:   if (grant_i) state_d = SLOT_ISSUED;
            SLOT_ISSUED: if (done_i)  state_d = SLOT_FREE;
            default:                  state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            op_o    <= '0;
            dst_o   <= '0;
            seq_o   <= '0;
            tag_a_q <= '0;
            tag_b_q <= '0;
            rdy_a_q <= 1'b0;
            rdy_b_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SLOT_FREE && alloc_i) begin
                op_o    <= op_i;
                dst_o   <= dst_i;
                seq_o   <= seq_i;
                tag_a_q <= tag_a_i;
                tag_b_q <= tag_b_i;
                rdy_a_q <= cap_a;
                rdy_b_q <= cap_b;
            end else if (state_q == SLOT_WAIT) begin
                if (hit_a) rdy_a_q <= 1'b1;
                if (hit_b) rdy_b_q <= 1'b1;
            end
        end
    end

    always_comb begin
        free_o = (state_q == SLOT_FREE);
        elig_o = (state_q == SLOT_WAIT) && rdy_a_q && rdy_b_q;
    end

endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int N_SLOT = 7,
    parameter int SLOT_W = 3
) (
    input  logic [N_SLOT-1:0]      free_i,
    input  logic [N_SLOT-1:0][1:0] cls_i,
    input  logic [1:0]             want_i,
    output logic                   found_o,
    output logic [SLOT_W-1:0]      idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N_SLOT - 1; i >= 0; i--) begin
            if (free_i[i] && (cls_i[i] == want_i)) begin
                found_o = 1'b1;
                idx_o   = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/rs_select.sv
module rs_select #(
    parameter int N_SLOT = 7,
    parameter int SLOT_W = 3,
    parameter int SEQ_W  = 6
) (
    input  logic [N_SLOT-1:0]            elig_i,
    input  logic [N_SLOT-1:0][SEQ_W-1:0] seq_i,
    output logic                         any_o,
    output logic [SLOT_W-1:0]            idx_o
);

    function automatic logic is_older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

    logic [SEQ_W-1:0] best_seq;

    always_comb begin
        any_o    = 1'b0;
        idx_o    = '0;
        best_seq = '0;
        for (int i = 0; i < N_SLOT; i++) begin
            if (elig_i[i] && (!any_o || is_older(seq_i[i], best_seq))) begin
                any_o    = 1'b1;
                idx_o    = SLOT_W'(i);
                best_seq = seq_i[i];
            end
        end
    end

endmodule

// File: rtl/resv_station.sv
module resv_station
    import rs_pkg::*;
#(
    parameter int N_ADD   = 1,
    parameter int N_MUL   = 2,
    parameter int N_LOAD  = 2,
    parameter int N_STORE = 2,
    parameter int TAG_W   = 6,
    parameter int OP_W    = 4,
    parameter int SEQ_W   = 6,
    localparam int N_SLOT = N_ADD + N_MUL + N_LOAD + N_STORE,
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [1:0]        disp_class,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic [TAG_W-1:0]  disp_src_a,
    input  logic              disp_use_a,
    input  logic              disp_rdy_a,
    input  logic [TAG_W-1:0]  disp_src_b,
    input  logic              disp_use_b,
    input  logic              disp_rdy_b,
    input  logic [SEQ_W-1:0]  disp_seq,
    output logic              disp_stall,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    output logic              issue_valid,
    output logic [SLOT_W-1:0] issue_slot,
    output logic [1:0]        issue_class,
    output logic [OP_W-1:0]   issue_op,
    output logic [TAG_W-1:0]  issue_dst,
    output logic [SEQ_W-1:0]  issue_seq,
    input  logic              done_valid,
    input  logic [SLOT_W-1:0] done_slot
);

    localparam int BASE_MUL   = N_ADD;
    localparam int BASE_LOAD  = N_ADD + N_MUL;
    localparam int BASE_STORE = N_ADD + N_MUL + N_LOAD;

    logic [N_SLOT-1:0]            slot_free, slot_elig;
    logic [N_SLOT-1:0]            slot_alloc, slot_grant, slot_done;
    logic [N_SLOT-1:0][1:0]       slot_cls;
    logic [N_SLOT-1:0][OP_W-1:0]  slot_op;
    logic [N_SLOT-1:0][TAG_W-1:0] slot_dst;
    logic [N_SLOT-1:0][SEQ_W-1:0] slot_seq;

    logic              alloc_found;
    logic [SLOT_W-1:0] alloc_idx;
    logic              alloc_ok;
    logic              sel_any;
    logic [SLOT_W-1:0] sel_idx;

    rs_alloc #(.N_SLOT(N_SLOT), .SLOT_W(SLOT_W)) alloc_i (
        .free_i  (slot_free),
        .cls_i   (slot_cls),
        .want_i  (disp_class),
        .found_o (alloc_found),
        .idx_o   (alloc_idx)
    );

    rs_select #(.N_SLOT(N_SLOT), .SLOT_W(SLOT_W), .SEQ_W(SEQ_W)) select_i (
        .elig_i (slot_elig),
        .seq_i  (slot_seq),
        .any_o  (sel_any),
        .idx_o  (sel_idx)
    );

    assign alloc_ok   = disp_valid && alloc_found;
    assign disp_stall = disp_valid && !alloc_found;

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        localparam logic [1:0] SLOT_CLS = (g < BASE_MUL)   ? CLS_ADD  :
                                          (g < BASE_LOAD)  ? CLS_MUL  :
                                          (g < BASE_STORE) ? CLS_LOAD : CLS_STORE;

        assign slot_cls[g]   = SLOT_CLS;
        assign slot_alloc[g] = alloc_ok && (alloc_idx == SLOT_W'(g));
        assign slot_grant[g] = sel_any && (sel_idx == SLOT_W'(g));
        assign slot_done[g]  = done_valid && (done_slot == SLOT_W'(g));

        rs_entry #(.TAG_W(TAG_W), .OP_W(OP_W), .SEQ_W(SEQ_W)) entry_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (slot_alloc[g]),
            .op_i        (disp_op),
            .dst_i       (disp_dst),
            .tag_a_i     (disp_src_a),
            .use_a_i     (disp_use_a),
            .rdy_a_i     (disp_rdy_a),
            .tag_b_i     (disp_src_b),
            .use_b_i     (disp_use_b),
            .rdy_b_i     (disp_rdy_b),
            .seq_i       (disp_seq),
            .cdb_valid_i (cdb_valid),
            .cdb_tag_i   (cdb_tag),
            .grant_i     (slot_grant[g]),
            .done_i      (slot_done[g]),
            .free_o      (slot_free[g]),
            .elig_o      (slot_elig[g]),
            .op_o        (slot_op[g]),
            .dst_o       (slot_dst[g]),
            .seq_o       (slot_seq[g])
        );
    end

    always_comb begin
        issue_valid = sel_any;
        issue_slot  = sel_idx;
        issue_class = slot_cls[sel_idx];
        issue_op    = slot_op[sel_idx];
        issue_seq   = slot_seq[sel_idx];
        issue_dst   = (slot_cls[sel_idx] == CLS_STORE) ? '0 : slot_dst[sel_idx];
    end

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
    parameter int N_SLOT = 7,
    parameter int SLOT_W = 3,
    parameter int TAG_W  = 6,
    parameter int SEQ_W  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         disp_valid,
    input  logic                         disp_stall,
    input  logic                         issue_valid,
    input  logic [SLOT_W-1:0]            issue_slot,
    input  logic [1:0]                   issue_class,
    input  logic [TAG_W-1:0]             issue_dst,
    input  logic [SEQ_W-1:0]             issue_seq,
    input  logic [N_SLOT-1:0]            elig,
    input  logic [N_SLOT-1:0][SEQ_W-1:0] seqs
);

    logic older_exists;

    always_comb begin
        older_exists = 1'b0;
        for (int i = 0; i < N_SLOT; i++) begin
            logic [SEQ_W-1:0] d;
            d = seqs[i] - issue_seq;
            if (elig[i] && d[SEQ_W-1]) older_exists = 1'b1;
        end
    end

    // R7
    oldest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !older_exists);

    // R7
    work_conserving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |-> issue_valid);

    // R4
    issue_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> elig[issue_slot]);

    // R8
    no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !(issue_valid && issue_slot == $past(issue_slot)));

    // R10
    store_no_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_class == 2'd3) |-> (issue_dst == '0));

    // R3
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stall |-> disp_valid);

endmodule

bind resv_station rs_checker #(
    .N_SLOT(N_SLOT), .SLOT_W(SLOT_W), .TAG_W(TAG_W), .SEQ_W(SEQ_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_valid  (disp_valid),
    .disp_stall  (disp_stall),
    .issue_valid (issue_valid),
    .issue_slot  (issue_slot),
    .issue_class (issue_class),
    .issue_dst   (issue_dst),
    .issue_seq   (issue_seq),
    .elig        (slot_elig),
    .seqs        (slot_seq)
);

// File: tb/resv_station_tb_top.sv
module resv_station_tb_top;

    localparam int NS = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_valid = 1'b0;
    logic [1:0] disp_class = '0;
    logic [3:0] disp_op = '0;
    logic [5:0] disp_dst = '0, disp_src_a = '0, disp_src_b = '0;
    logic       disp_use_a = 1'b0, disp_rdy_a = 1'b0, disp_use_b = 1'b0, disp_rdy_b = 1'b0;
    logic [5:0] disp_seq = '0;
    logic       disp_stall;
    logic       cdb_valid = 1'b0;
    logic [5:0] cdb_tag = '0;
    logic       issue_valid;
    logic [2:0] issue_slot;
    logic [1:0] issue_class;
    logic [3:0] issue_op;
    logic [5:0] issue_dst, issue_seq;
    logic       done_valid = 1'b0;
    logic [2:0] done_slot = '0;

    always #2 clk = ~clk;

    resv_station dut_i (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_class(disp_class), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_src_a(disp_src_a), .disp_use_a(disp_use_a), .disp_rdy_a(disp_rdy_a),
        .disp_src_b(disp_src_b), .disp_use_b(disp_use_b), .disp_rdy_b(disp_rdy_b),
        .disp_seq(disp_seq), .disp_stall(disp_stall),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .issue_valid(issue_valid), .issue_slot(issue_slot), .issue_class(issue_class),
        .issue_op(issue_op), .issue_dst(issue_dst), .issue_seq(issue_seq),
        .done_valid(done_valid), .done_slot(done_slot)
    );

    int n_chk = 0;
    int n_err = 0;

    // reference model: 0 free, 1 waiting, 2 issued
    int         m_st  [NS];
    logic [3:0] m_op  [NS];
    logic [5:0] m_dst [NS];
    logic [5:0] m_ta  [NS];
    logic [5:0] m_tb  [NS];
    bit         m_ra  [NS];
    bit         m_rb  [NS];
    logic [5:0] m_seq [NS];
    logic [5:0] seq_ctr = '0;

    function automatic int cls_of(int s);
        if (s < 1) return 0;
        if (s < 3) return 1;
        if (s < 5) return 2;
        return 3;
    endfunction

    function automatic bit older(logic [5:0] a, logic [5:0] b);
        logic [5:0] d;
        d = a - b;
        return d[5];
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        disp_valid = 1'b0; cdb_valid = 1'b0; done_valid = 1'b0;
    endtask

    task automatic drv_disp(int cls, int op, int dst, int ta, bit ua, bit ra, int tb, bit ub, bit rb);
        disp_valid = 1'b1; disp_class = 2'(cls); disp_op = 4'(op); disp_dst = 6'(dst);
        disp_src_a = 6'(ta); disp_use_a = ua; disp_rdy_a = ra;
        disp_src_b = 6'(tb); disp_use_b = ub; disp_rdy_b = rb;
        disp_seq = seq_ctr;
    endtask

    // inputs already driven after a falling edge; compare, then advance the model at the rising edge
    task automatic step();
        int al, sel;
        #1;
        al = -1;
        if (disp_valid)
            for (int s = 0; s < NS; s++)
                if (al < 0 && m_st[s] == 0 && cls_of(s) == int'(disp_class)) al = s;
        chk("R3", "disp_stall", int'(disp_stall), int'(disp_valid && al < 0));
        sel = -1;
        for (int s = 0; s < NS; s++)
            if (m_st[s] == 1 && m_ra[s] && m_rb[s])
                if (sel < 0 || older(m_seq[s], m_seq[sel])) sel = s;
        chk("R7", "issue_valid", int'(issue_valid), int'(sel >= 0));
        if (sel >= 0 && issue_valid) begin
            chk("R7", "issue_slot", int'(issue_slot), sel);
            chk("R2", "issue_class", int'(issue_class), cls_of(sel));
            chk("R11", "issue_op", int'(issue_op), int'(m_op[sel]));
            chk("R11", "issue_seq", int'(issue_seq), int'(m_seq[sel]));
            chk(cls_of(sel) == 3 ? "R10" : "R11", "issue_dst", int'(issue_dst),
                cls_of(sel) == 3 ? 0 : int'(m_dst[sel]));
        end
        @(posedge clk);
        if (done_valid && m_st[done_slot] == 2) m_st[done_slot] = 0;
        if (sel >= 0) m_st[sel] = 2;
        if (cdb_valid)
            for (int s = 0; s < NS; s++)
                if (m_st[s] == 1) begin
                    if (m_ta[s] == cdb_tag) m_ra[s] = 1'b1;
                    if (m_tb[s] == cdb_tag) m_rb[s] = 1'b1;
                end
        if (al >= 0) begin
            m_st[al] = 1; m_op[al] = disp_op; m_dst[al] = disp_dst; m_seq[al] = disp_seq;
            m_ta[al] = disp_src_a; m_tb[al] = disp_src_b;
            m_ra[al] = disp_rdy_a || !disp_use_a || (cdb_valid && cdb_tag == disp_src_a);
            m_rb[al] = disp_rdy_b || !disp_use_b || (cdb_valid && cdb_tag == disp_src_b);
            seq_ctr++;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int rnd;
        rnd = $urandom(32'h5eed_0017);
        for (int s = 0; s < NS; s++) m_st[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        #1;
        chk("R1", "issue_valid after reset", int'(issue_valid), 0);
        chk("R1", "disp_stall after reset", int'(disp_stall), 0);
        step();
        // R2 R4: add with unready source A parks in slot 0
        drv_disp(0, 1, 7, 5, 1, 0, 0, 0, 0); step();
        // R3: second add finds the class full
        drv_disp(0, 2, 8, 1, 0, 0, 0, 0, 0); step();
        chk("R4", "no issue while source waits", int'(issue_valid), 0);
        // R6: multiply whose source is broadcast during dispatch
        drv_disp(1, 3, 9, 9, 1, 0, 3, 0, 0); cdb_valid = 1; cdb_tag = 9; step();
        step();
        // R9: done aimed at waiting slot 0 is ignored
        done_valid = 1; done_slot = 0; step();
        // R5: wake slot 0 and watch it issue next cycle
        cdb_valid = 1; cdb_tag = 5; step();
        step();
        // R9: release the multiply and the add, then reuse slot 0
        done_valid = 1; done_slot = 1; step();
        done_valid = 1; done_slot = 0; step();
        drv_disp(0, 4, 10, 0, 0, 0, 0, 0, 0); step();
        step();
        done_valid = 1; done_slot = 0; step();
        // R7 R10: age wrap across two loads and a store sharing one tag
        seq_ctr = 6'd62;
        drv_disp(2, 5, 11, 12, 1, 0, 0, 0, 0); step();
        drv_disp(2, 6, 12, 12, 1, 0, 0, 0, 0); step();
        drv_disp(3, 7, 33, 2, 1, 1, 12, 1, 0); step();
        cdb_valid = 1; cdb_tag = 12; step();
        step(); step(); step();
        for (int s = 3; s < NS; s++) begin done_valid = 1; done_slot = 3'(s); step(); end
        // random phase
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 10 < 6)
                drv_disp($urandom % 4, $urandom % 16, $urandom % 64,
                         $urandom % 8, 1'($urandom % 2), 1'($urandom % 10 < 3),
                         $urandom % 8, 1'($urandom % 2), 1'($urandom % 10 < 3));
            if ($urandom % 2 == 1) begin cdb_valid = 1; cdb_tag = 6'($urandom % 8); end
            if ($urandom % 10 < 7) begin
                int st0;
                st0 = $urandom % NS;
                for (int k = 0; k < NS; k++)
                    if (!done_valid && m_st[(st0 + k) % NS] == 2) begin
                        done_valid = 1; done_slot = 3'((st0 + k) % NS);
                    end
            end else if ($urandom % 2 == 1) begin
                done_valid = 1; done_slot = 3'($urandom % NS);
            end
            step();
        end
        finish_run();
    end

endmodule